// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

This block sits between three external interrupt pins and a parent interrupt controller that accepts only active-high levels and rising edges. Each pin is synchronized, then either passed through as a level (straight or inverted) or reduced to a single-cycle request pulse when the selected edge appears (rising or falling). A falling edge leads to the same pulse a rising edge would. The parent therefore sees one normalized request per line whatever the pin polarity.

Software configures each line through an 8-bit control field that holds a trigger type, an enable, a sampling-rate select and a pending flag. When the `SHARED_WORD` parameter is set, the three fields are packed into one 32-bit word and byte enables pick the field a write touches. When it is clear, each line has its own word at its own address. In edge modes the pending flag records that an event arrived, and software clears it by writing 1 to it. In level modes the same bit shows the conditioned level as it is now.

Top module: `extirq_conditioner`

## Requirements
- R1: After reset every control field reads zero (disabled, active-high level, nothing pending), and all three outputs are low.
- R2: Field layout: bit 0 is pending (write 1 clears), bit 4 selects the fast sampling rate, bit 5 enables, bits 7:6 are the trigger type with 00 = active high, 01 = active low, 10 = rising edge, 11 = falling edge. All other bits read zero.
- R3: In level modes with fast sampling, an enabled output follows the pin (type 00) or its inverse (type 01). A pin change shows at the output after the third rising clock edge and not before.
- R4: In edge modes with fast sampling, the selected edge (rising for 10, falling for 11) on an enabled line gives exactly one output cycle high, after the third rising clock edge. The opposite edge gives nothing.
- R5: In edge modes the pending bit becomes 1 in the same cycle as the output pulse. It stays 1 until software writes 1 to bit 0 of that field.
- R6: If a qualifying edge and a write-one clear of the same line fall in the same cycle, the edge wins and pending stays 1.
- R7: In level modes the pending bit reads back the line's conditioned level (pin, or inverted pin for type 01).
- R8: While enable is 0, the line's output stays low and edges are not latched into pending.
- R9: Shared-word mode: line 0 sits at bits 23:16 (byte lane 2), line 1 at bits 15:8 (lane 1), line 2 at bits 7:0 (lane 0). A write changes only the fields whose byte enable is set, and the read address is ignored.
- R10: Separate-word mode: write and read address N (0 to 2) selects line N. Its field sits in bits 7:0 with write byte enable 0, and bits 31:8 read zero.
- R11: With the fast-select bit at 0, the pin is sampled only once every `SLOW_DIV` clocks (default 4). A level change then takes at least six clocks to reach the output. With the bit at 1 the pin is sampled every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write word address (separate-word mode only) |
| wrByteEn | input | 4 | Write byte enables |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read word address (separate-word mode only) |
| rdData | output | 32 | Combinational read data |
| irqIn | input | 3 | Raw external interrupt pins |
| irqOut | output | 3 | Conditioned active-high requests to the parent controller |

## Verification
The bench first aims at the race between a new falling edge and a write-one clear that land on the same edge. A design that let the clear win would show pending at 0 and lose an interrupt. Shared-word writes are sent with garbage in the disabled byte lanes: a design that ignored the byte enables would corrupt a neighbour's type or enable, and the readback would show it. Edge mode is checked on both edges and one cycle past the pulse, so a stretched pulse fails the check, and so does a pulse on the wrong polarity. Latency is checked one cycle early and again with slow sampling, where a design that ignored the rate select would drop its output three cycles after the pin changed. The bench also checks that disabling a line holds its output low and blocks latching.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int FIELD_W    = 8;
  localparam int BIT_PEND   = 0;
  localparam int BIT_FAST   = 4;
  localparam int BIT_EN     = 5;
  localparam int BIT_TRIG   = 6;

  // Trigger type codes; bit 1 selects edge, bit 0 selects inversion
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  en;
    logic  fast;
  } line_cfg_t;

  // Strobes and settings the control half hands to the datapath per line
  typedef struct packed {
    logic      clrPend;
    line_cfg_t cfg;
  } line_strobe_t;

  function automatic logic trigIsEdge(trig_e t);
    return t[1];
  endfunction

  function automatic logic trigIsInv(trig_e t);
    return t[0];
  endfunction

endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 3,
  parameter bit SHARED_WORD = 1'b1,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [DATA_W/8-1:0]                 wrByteEn,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [DATA_W-1:0]                   rdData,
  input  logic [NUM_LINES-1:0]                pendView,
  output line_strobe_t [NUM_LINES-1:0]        lineCtl
);

  localparam int LANES = DATA_W / FIELD_W;

  logic [NUM_LINES-1:0][FIELD_W-1:0] fieldView;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic               hit;
    logic [FIELD_W-1:0] wrField;
    line_cfg_t          cfgQ;

    if (SHARED_WORD) begin : g_shared
      // line 0 occupies the highest used lane, the last line lane 0
      localparam int LANE = NUM_LINES - 1 - i;
      assign hit     = wrEn & wrByteEn[LANE];
      assign wrField = wrData[LANE*FIELD_W +: FIELD_W];
    end else begin : g_split
      assign hit     = wrEn & (wrAddr == ADDR_W'(i)) & wrByteEn[0];
      assign wrField = wrData[FIELD_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ <= '0;
      end else if (hit) begin
        cfgQ.trig <= trig_e'(wrField[BIT_TRIG +: 2]);
        cfgQ.en   <= wrField[BIT_EN];
        cfgQ.fast <= wrField[BIT_FAST];
      end
    end

    assign lineCtl[i].cfg     = cfgQ;
    assign lineCtl[i].clrPend = hit & wrField[BIT_PEND];

    assign fieldView[i] = {cfgQ.trig, cfgQ.en, cfgQ.fast, 3'b000, pendView[i]};
  end

  initial begin
    if (SHARED_WORD && NUM_LINES > LANES)
      $error("extirq_ctrl: too many lines for one shared word");
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (SHARED_WORD) begin
        rdData[(NUM_LINES-1-i)*FIELD_W +: FIELD_W] = fieldView[i];
      end else if (rdAddr == ADDR_W'(i)) begin
        rdData[FIELD_W-1:0] = fieldView[i];
      end
    end
  end

endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int SLOW_DIV  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          irqIn,
  input  line_strobe_t [NUM_LINES-1:0]  lineCtl,
  output logic [NUM_LINES-1:0]          pendView,
  output logic [NUM_LINES-1:0]          irqOut
);

  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             slowTick;

  assign slowTick = (divCnt == DIV_W'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || slowTick) divCnt <= '0;
    else                   divCnt <= divCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_cfg_t  cfg;
    logic       sampleEn;
    logic [1:0] syncQ;
    logic       condNow;
    logic       condPrevQ;
    logic       edgeFire;
    logic       pendQ;
    logic       outQ;

    assign cfg      = lineCtl[i].cfg;
    assign sampleEn = cfg.fast | slowTick;
    assign condNow  = syncQ[1] ^ trigIsInv(cfg.trig);
    assign edgeFire = sampleEn & cfg.en & trigIsEdge(cfg.trig) & condNow & ~condPrevQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ     <= '0;
        condPrevQ <= 1'b0;
      end else if (sampleEn) begin
        syncQ     <= {syncQ[0], irqIn[i]};
        condPrevQ <= condNow;
      end
    end

    // a fresh edge outranks a same-cycle clear
    always_ff @(posedge clk) begin
      if (!rstN)                   pendQ <= 1'b0;
      else if (edgeFire)           pendQ <= 1'b1;
      else if (lineCtl[i].clrPend) pendQ <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) outQ <= 1'b0;
      else       outQ <= cfg.en & (trigIsEdge(cfg.trig) ? edgeFire : condNow);
    end

    assign pendView[i] = trigIsEdge(cfg.trig) ? pendQ : condNow;
    assign irqOut[i]   = outQ;
  end

endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 3,
  parameter bit SHARED_WORD = 1'b1,
  parameter int SLOW_DIV    = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W/8-1:0]    wrByteEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [DATA_W-1:0]      rdData,
  input  logic [NUM_LINES-1:0]   irqIn,
  output logic [NUM_LINES-1:0]   irqOut
);

  line_strobe_t [NUM_LINES-1:0] lineCtl;
  logic [NUM_LINES-1:0]         pendView;

  extirq_ctrl #(
    .NUM_LINES  (NUM_LINES),
    .SHARED_WORD(SHARED_WORD),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrByteEn(wrByteEn),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .pendView(pendView),
    .lineCtl (lineCtl)
  );

  extirq_datapath #(
    .NUM_LINES(NUM_LINES),
    .SLOW_DIV (SLOW_DIV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .lineCtl (lineCtl),
    .pendView(pendView),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/extirq_checker.sv
module extirq_checker
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 3,
  parameter bit SHARED_WORD = 1'b1,
  parameter int DATA_W      = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [DATA_W/8-1:0]           wrByteEn,
  input line_strobe_t [NUM_LINES-1:0]  lineCtl,
  input logic [NUM_LINES-1:0]          pendView,
  input logic [NUM_LINES-1:0]          irqOut
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    // R8: a disabled line produces no request on the next cycle
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !lineCtl[i].cfg.en |=> !irqOut[i]);

    // R4: an edge-mode request lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[i] && lineCtl[i].cfg.trig[1] && $stable(lineCtl[i].cfg.trig)) |=> !irqOut[i]);

    // R5: each edge-mode request coincides with pending set
    a_r5_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[i] && lineCtl[i].cfg.trig[1] && $stable(lineCtl[i].cfg.trig)) |-> pendView[i]);

    // R5: pending holds until a clear strobe
    a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
      (lineCtl[i].cfg.trig[1] && pendView[i] && !lineCtl[i].clrPend)
        |=> (pendView[i] || !lineCtl[i].cfg.trig[1]));

    if (SHARED_WORD) begin : g_iso
      localparam int LANE = NUM_LINES - 1 - i;
      // R9: a write without this line's byte enable leaves its settings alone
      a_r9_lane_isolation: assert property (@(posedge clk) disable iff (!rstN)
        !(wrEn && wrByteEn[LANE]) |=> $stable(lineCtl[i].cfg));
    end
  end

endmodule

bind extirq_conditioner extirq_checker #(
  .NUM_LINES  (NUM_LINES),
  .SHARED_WORD(SHARED_WORD),
  .DATA_W     (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrByteEn(wrByteEn),
  .lineCtl (lineCtl),
  .pendView(pendView),
  .irqOut  (irqOut)
);

// File: tb/extirq_conditioner_test.sv
module extirq_conditioner_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 1'b0, wrEnB = 1'b0;
  logic [1:0]  wrAddr = '0, rdAddr = '0;
  logic [3:0]  wrByteEn = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  irqIn = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [2:0]  irqOutA, irqOutB;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  extirq_conditioner #(.SHARED_WORD(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEnA), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdDataA), .irqIn(irqIn), .irqOut(irqOutA));

  extirq_conditioner #(.SHARED_WORD(1'b0)) uutSep (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdDataB), .irqIn(irqIn), .irqOut(irqOutB));

  typedef struct { int at; int line; logic val; string req; } exp_t;
  exp_t sbQ[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side: schedule an expected output value some cycles ahead
  task automatic expectOut(int delay, int line, logic val, string req);
    exp_t e;
    e.at = cyc + delay; e.line = line; e.val = val; e.req = req;
    sbQ.push_back(e);
  endtask

  // monitor side: compare as the design produces its outputs
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].at <= cyc) begin
      exp_t e;
      e = sbQ.pop_front();
      if (e.at < cyc) check({e.req, " missed slot"}, 32'(cyc), 32'(e.at));
      else            check(e.req, 32'(irqOutA[e.line]), 32'(e.val));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(bit toSep, logic [1:0] addr, logic [3:0] be, logic [31:0] data);
    @(negedge clk);
    wrAddr = addr; wrByteEn = be; wrData = data;
    if (toSep) wrEnB = 1'b1; else wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0; wrByteEn = '0;
  endtask

  task automatic drivePin(int line, logic v);
    @(negedge clk);
    irqIn[line] = v;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: cleared fields and quiet outputs
    check("R1 fields", rdDataA, 32'h0);
    check("R1 outputs", 32'(irqOutA), 32'h0);

    // R3: line 0 active-high level, fast sampling (field 0x30 in lane 2)
    regWrite(0, 2'd0, 4'b0100, 32'h0030_0000);
    drivePin(0, 1'b1);
    expectOut(2, 0, 1'b0, "R3 too early");
    expectOut(3, 0, 1'b1, "R3 level high");
    step(4);
    check("R7 level pending reads pin", rdDataA, 32'h0031_0000);
    drivePin(0, 1'b0);
    expectOut(3, 0, 1'b0, "R3 level low");
    step(4);

    // R9: line 1 write with garbage in disabled lanes
    regWrite(0, 2'd3, 4'b0010, 32'hFFFF_B0FF);
    check("R9 lane isolation R2", rdDataA, 32'h0030_B000);

    // R3 / R7: line 2 active low, pin currently low
    regWrite(0, 2'd0, 4'b0001, 32'h0000_0070);
    step(3);
    check("R3 active low asserted", 32'(irqOutA[2]), 32'h1);
    check("R7 inverted level pending", 32'(rdDataA[7:0]), 32'h71);
    drivePin(2, 1'b1);
    expectOut(2, 2, 1'b1, "R3 low not yet");
    expectOut(3, 2, 1'b0, "R3 low deasserted");
    step(4);

    // R4 / R5: line 1 rising edge
    drivePin(1, 1'b1);
    expectOut(2, 1, 1'b0, "R4 rise early");
    expectOut(3, 1, 1'b1, "R4 rise pulse");
    expectOut(4, 1, 1'b0, "R4 pulse one cycle");
    step(5);
    check("R5 pending set", 32'(rdDataA[15:8]), 32'hB1);
    drivePin(1, 1'b0);
    expectOut(3, 1, 1'b0, "R4 falling ignored in rise mode");
    expectOut(4, 1, 1'b0, "R4 falling ignored late");
    step(6);
    check("R5 pending holds", 32'(rdDataA[15:8]), 32'hB1);
    regWrite(0, 2'd0, 4'b0010, 32'h0000_B100);
    check("R5 write one clears", 32'(rdDataA[15:8]), 32'hB0);

    // R4: falling mode, programmed while disabled, then enabled
    regWrite(0, 2'd0, 4'b0010, 32'h0000_D000);
    step(3);
    regWrite(0, 2'd0, 4'b0010, 32'h0000_F000);
    step(3);
    check("R4 no spurious pending", 32'(rdDataA[15:8]), 32'hF0);
    drivePin(1, 1'b1);
    expectOut(3, 1, 1'b0, "R4 rising ignored in fall mode");
    step(5);
    drivePin(1, 1'b0);
    expectOut(3, 1, 1'b1, "R4 fall pulse");
    expectOut(4, 1, 1'b0, "R4 fall pulse one cycle");
    step(5);
    check("R4 fall pending", 32'(rdDataA[15:8]), 32'hF1);

    // R6: clear lands on the same edge that latches a new falling edge
    drivePin(1, 1'b1);
    step(5);
    drivePin(1, 1'b0);
    expectOut(3, 1, 1'b1, "R6 pulse");
    step(1);
    regWrite(0, 2'd0, 4'b0010, 32'h0000_F100);
    check("R6 edge beats clear", 32'(rdDataA[15:8]), 32'hF1);
    regWrite(0, 2'd0, 4'b0010, 32'h0000_F100);
    check("R5 clear after race", 32'(rdDataA[15:8]), 32'hF0);

    // R8: disabled lines stay quiet and latch nothing
    regWrite(0, 2'd0, 4'b0100, 32'h0010_0000);
    drivePin(0, 1'b1);
    expectOut(3, 0, 1'b0, "R8 disabled level");
    expectOut(6, 0, 1'b0, "R8 disabled level later");
    step(7);
    drivePin(1, 1'b1);
    step(5);
    regWrite(0, 2'd0, 4'b0010, 32'h0000_D000);
    drivePin(1, 1'b0);
    expectOut(3, 1, 1'b0, "R8 disabled edge");
    step(6);
    check("R8 no pending while disabled", 32'(rdDataA[15:8]), 32'hD0);

    // R11: slow sampling on line 0 (field 0x20), pin already high
    regWrite(0, 2'd0, 4'b0100, 32'h0020_0000);
    step(3);
    check("R11 slow level up", 32'(irqOutA[0]), 32'h1);
    drivePin(0, 1'b0);
    expectOut(3, 0, 1'b1, "R11 slow not yet sampled");
    expectOut(5, 0, 1'b1, "R11 slow minimum latency");
    begin
      int waited = 0;
      while (irqOutA[0] !== 1'b0 && waited < 20) begin
        step(1);
        waited++;
      end
      check("R11 slow eventually low", 32'(irqOutA[0]), 32'h0);
    end

    // R10: separate-word instance, line 1 at address 1
    regWrite(1, 2'd1, 4'b0001, 32'hFFFF_FF30);
    rdAddr = 2'd1;
    step(1);
    check("R10 addressed field", rdDataB, 32'h0000_0030);
    rdAddr = 2'd0;
    step(1);
    check("R10 other address untouched", rdDataB, 32'h0);
    drivePin(1, 1'b1);
    step(4);
    check("R10 line 1 output", 32'(irqOutB), 32'b010);

    while (sbQ.size() > 0) step(1);
    step(2);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule